// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This unit sits between an on-chip master address bus and the address bus that goes out to the PCIe side. Each incoming address first has a fixed bus offset taken away from it, which gives an internal address. The internal address is then compared with two programmable region bases. When an enabled region covers the address, the region's upper bits are replaced by the upper bits of that window's own 64-bit target base. The bits below the window size pass through unchanged. The unit reports a hit with the translated address, or a miss with a zero address.

Software sets up each window through a small 32-bit register port: a region low and high word and a target low and high word. Bit 0 of the region low word enables the window. Bit 1 of the same word doubles that window's size. All windows share one default size of 2^WIN_SHIFT bytes. The result is registered and appears one cycle after the request.

Top module: `outbound_xlate`

## Requirements
- R1: After reset every window register reads zero, out_valid, out_hit and out_miss are low, and a translation request misses.
- R2: Byte offsets for window n: region low at 0xD20+8n, region high at 0xD24+8n, target low at 0xD40+8n, target high at 0xD44+8n. A write with cfg_wr high updates the register at cfg_addr on the clock edge. cfg_rdata shows the register at cfg_addr in the same cycle, as last written, all 32 bits.
- R3: A window whose region low bit 0 is clear never hits, whatever its base is.
- R4: The internal address is in_addr minus BUS_OFFSET. Any in_addr below BUS_OFFSET gives a miss.
- R5: The region base is {region high, region low[31:2], 2'b00}. With region low bit 1 clear, a window hits when the internal address and the region base agree above bit WIN_SHIFT-1. The output is then the target base {target high, target low} with its low WIN_SHIFT bits replaced by those of the internal address.
- R6: With region low bit 1 set, the same rule applies with WIN_SHIFT+1 in place of WIN_SHIFT, so the window covers twice the span.
- R7: When both windows hit, window 0 supplies the result.
- R8: On a miss, out_miss is 1, out_hit is 0 and out_addr is zero. On a hit, out_hit is 1 and out_miss is 0.
- R9: out_valid follows in_valid one cycle later. While out_valid is low, out_hit and out_miss are low.
- R10: Writes to offsets other than the eight window registers change nothing, and reads of such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | RAW | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| in_valid | input | 1 | Translation request valid |
| in_addr | input | 64 | Incoming bus address |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_addr | output | 64 | Translated address, zero on a miss |
| out_hit | output | 1 | An enabled window matched |
| out_miss | output | 1 | No enabled window matched |

## Verification
Addresses are sent just inside and just past a default-size window. This separates the default span from the doubled span once the size bit is set.

Two windows are given overlapping bases. Window 0 is then disabled, which shows the priority order and that the enable bit is honoured. Addresses just below the bus offset and at zero check the guard on the subtraction. A region base above 4 GiB checks that the high words take part.

Back-to-back and idle request cycles are compared on every clock against a behavioural model that uses division and remainder. Writes to unused and misaligned offsets are read back to show they change nothing.

// File: rtl/outbound_xlate.sv
module outbound_xlate #(
  parameter int          WIN_SHIFT  = 20,
  parameter logic [63:0] BUS_OFFSET = 64'h0000_0000_2000_0000,
  parameter int          RAW        = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [RAW-1:0] cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  input  logic           in_valid,
  input  logic [63:0]    in_addr,
  output logic           out_valid,
  output logic [63:0]    out_addr,
  output logic           out_hit,
  output logic           out_miss
);
  localparam int          NW      = 2;
  localparam logic [63:0] PASS_S  = (64'd1 << WIN_SHIFT) - 64'd1;
  localparam logic [63:0] PASS_D  = (64'd1 << (WIN_SHIFT + 1)) - 64'd1;

  logic [31:0] rlo [NW];
  logic [31:0] rhi [NW];
  logic [31:0] mlo [NW];
  logic [31:0] mhi [NW];

  function automatic logic [RAW-1:0] offs(input int base, input int n);
    return RAW'(base + 8 * n);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NW; n++) begin
        rlo[n] <= '0; rhi[n] <= '0; mlo[n] <= '0; mhi[n] <= '0;
      end
    end else if (cfg_wr) begin
      for (int n = 0; n < NW; n++) begin
        if (cfg_addr == offs(32'hD20, n)) rlo[n] <= cfg_wdata;
        if (cfg_addr == offs(32'hD24, n)) rhi[n] <= cfg_wdata;
        if (cfg_addr == offs(32'hD40, n)) mlo[n] <= cfg_wdata;
        if (cfg_addr == offs(32'hD44, n)) mhi[n] <= cfg_wdata;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int n = 0; n < NW; n++) begin
      if (cfg_addr == offs(32'hD20, n)) cfg_rdata = rlo[n];
      if (cfg_addr == offs(32'hD24, n)) cfg_rdata = rhi[n];
      if (cfg_addr == offs(32'hD40, n)) cfg_rdata = mlo[n];
      if (cfg_addr == offs(32'hD44, n)) cfg_rdata = mhi[n];
    end
  end

  wire        below    = in_addr < BUS_OFFSET;
  wire [63:0] internal = in_addr - BUS_OFFSET;

  logic [NW-1:0] hit;
  logic [63:0]   xl [NW];

  for (genvar n = 0; n < NW; n++) begin : g_win
    wire [63:0] base = {rhi[n], rlo[n][31:2], 2'b00};
    wire [63:0] tgt  = {mhi[n], mlo[n]};
    wire [63:0] pass = rlo[n][1] ? PASS_D : PASS_S;
    assign hit[n] = rlo[n][0] & ~below & ((internal & ~pass) == (base & ~pass));
    assign xl[n]  = (tgt & ~pass) | (internal & pass);
  end

  wire [63:0] sel_addr = hit[0] ? xl[0] : (hit[1] ? xl[1] : 64'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_hit <= 1'b0; out_miss <= 1'b0; out_addr <= '0;
    end else begin
      out_valid <= in_valid;
      out_hit   <= in_valid & (|hit);
      out_miss  <= in_valid & ~(|hit);
      out_addr  <= in_valid ? sel_addr : 64'd0;
    end
  end

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_hit && !out_miss));
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hit != out_miss));
  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_miss |-> (out_addr == 64'd0));
  assert_below_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr < BUS_OFFSET) |=> out_miss);
  assert_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rlo[0][0] && !rlo[1][0]) |=> out_miss);
endmodule

// File: tb/test_outbound_xlate.sv
module test_outbound_xlate;
  localparam logic [63:0] OFF = 64'h0000_0000_2000_0000;
  localparam int WS = 20;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0;
  logic [11:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic in_valid = 0;
  logic [63:0] in_addr = 0, out_addr;
  logic out_valid, out_hit, out_miss;

  outbound_xlate #(.WIN_SHIFT(WS), .BUS_OFFSET(OFF), .RAW(12)) i_outbound_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
    .in_addr(in_addr), .out_valid(out_valid), .out_addr(out_addr),
    .out_hit(out_hit), .out_miss(out_miss));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  logic [31:0] m_reg [4][2];
  logic e_valid = 0, e_hit = 0, e_miss = 0;
  logic [63:0] e_addr = 0;

  function automatic int slot(input logic [11:0] a, output int w);
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 2; n++)
        if (a == 12'hD20 + 12'(k * 4) + 12'(k >= 2 ? 24 : 0) + 12'(8 * n)) begin
          w = n; return k;
        end
    w = 0; return -1;
  endfunction

  task automatic model_xlate(input logic [63:0] a, output logic h, output logic [63:0] r);
    logic [63:0] intl, sz, base, tgt;
    h = 0; r = 0;
    if (a < OFF) return;
    intl = a - OFF;
    for (int n = 0; n < 2; n++) begin
      if (!h && m_reg[0][n][0]) begin
        sz   = m_reg[0][n][1] ? (64'd2 << WS) : (64'd1 << WS);
        base = {m_reg[1][n], m_reg[0][n] & 32'hFFFF_FFFC};
        tgt  = {m_reg[3][n], m_reg[2][n]};
        if (intl / sz == base / sz) begin
          h = 1; r = (tgt / sz) * sz + intl % sz;
        end
      end
    end
  endtask

  initial for (int k = 0; k < 4; k++) for (int n = 0; n < 2; n++) m_reg[k][n] = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_valid <= 0; e_hit <= 0; e_miss <= 0; e_addr <= 0;
    end else begin
      logic h; logic [63:0] r; int w, k;
      model_xlate(in_addr, h, r);
      e_valid <= in_valid;
      e_hit   <= in_valid && h;
      e_miss  <= in_valid && !h;
      e_addr  <= in_valid ? r : 64'd0;
      if (cfg_wr) begin
        k = slot(cfg_addr, w);
        if (k >= 0) m_reg[k][w] = cfg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (out_valid !== e_valid || out_hit !== e_hit || out_miss !== e_miss || out_addr !== e_addr) begin
      errors++;
      $display("FAIL %s model: act v%b h%b m%b %h exp v%b h%b m%b %h", cur_req,
               out_valid, out_hit, out_miss, out_addr, e_valid, e_hit, e_miss, e_addr);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rd_check(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); cfg_addr = a; #1;
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read %h: act %h exp %h", req, a, cfg_rdata, exp);
    end
  endtask

  task automatic xl_check(input logic [63:0] a, input logic hit, input logic [63:0] exp, input string req);
    cur_req = req;
    @(negedge clk); in_valid = 1; in_addr = a;
    @(negedge clk); in_valid = 0;
    #1; checks++;
    if (out_valid !== 1 || out_hit !== hit || out_miss !== !hit || out_addr !== exp) begin
      errors++;
      $display("FAIL %s xlate %h: act h%b m%b %h exp h%b %h", req, a, out_hit, out_miss, out_addr, hit, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    checks++;
    if (out_valid !== 0 || out_hit !== 0 || out_miss !== 0) begin
      errors++; $display("FAIL R1 reset outputs: act %b%b%b exp 000", out_valid, out_hit, out_miss);
    end
    for (int n = 0; n < 2; n++) begin
      rd_check(12'hD20 + 12'(8*n), 0, "R1");
      rd_check(12'hD24 + 12'(8*n), 0, "R1");
      rd_check(12'hD40 + 12'(8*n), 0, "R1");
      rd_check(12'hD44 + 12'(8*n), 0, "R1");
    end
    xl_check(OFF + 64'h40_0000, 0, 0, "R1");

    wr(12'hD20, 32'h0040_0000);
    wr(12'hD40, 32'h8000_0000);
    wr(12'hD44, 32'h0000_0001);
    xl_check(OFF + 64'h43_2100, 0, 0, "R3");
    wr(12'hD20, 32'h0040_0001);
    rd_check(12'hD20, 32'h0040_0001, "R2");
    rd_check(12'hD40, 32'h8000_0000, "R2");
    rd_check(12'hD44, 32'h0000_0001, "R2");
    xl_check(OFF + 64'h43_2100, 1, 64'h1_8003_2100, "R5");
    xl_check(OFF + 64'h4F_FFFF, 1, 64'h1_800F_FFFF, "R5");
    xl_check(OFF + 64'h53_0000, 0, 0, "R8");

    wr(12'hD20, 32'h0040_0003);
    xl_check(OFF + 64'h53_0000, 1, 64'h1_8013_0000, "R6");
    xl_check(OFF + 64'h60_0000, 0, 0, "R6");
    wr(12'hD20, 32'h0040_0001);

    wr(12'hD28, 32'h0050_0001);
    wr(12'hD48, 32'h8010_0000);
    wr(12'hD4C, 32'h0000_0001);
    xl_check(OFF + 64'h50_0010, 1, 64'h1_8010_0010, "R5");

    wr(12'hD28, 32'h0040_0001);
    wr(12'hD4C, 32'h0000_0002);
    wr(12'hD48, 32'h0000_0000);
    xl_check(OFF + 64'h40_0500, 1, 64'h1_8000_0500, "R7");
    wr(12'hD20, 32'h0040_0002);
    xl_check(OFF + 64'h40_0500, 1, 64'h2_0000_0500, "R3");

    wr(12'hD20, 32'h0000_0001);
    wr(12'hD44, 32'h0000_0003);
    xl_check(OFF + 64'h10, 1, 64'h3_8000_0010, "R4");
    xl_check(OFF - 64'h10, 0, 0, "R4");
    xl_check(64'h0, 0, 0, "R4");

    wr(12'hD2C, 32'h0000_0001);
    wr(12'hD28, 32'h0000_0001);
    rd_check(12'hD2C, 32'h0000_0001, "R2");
    xl_check(OFF + 64'h1_0000_0040, 1, 64'h2_0000_0040, "R2");

    wr(12'hD30, 32'hFFFF_FFFF);
    wr(12'hD22, 32'hFFFF_FFFF);
    rd_check(12'hD30, 0, "R10");
    rd_check(12'hD22, 0, "R10");
    rd_check(12'hD20, 32'h0000_0001, "R10");
    rd_check(12'hD24, 32'h0000_0000, "R10");
    rd_check(12'hD28, 32'h0000_0001, "R10");

    cur_req = "R9";
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      in_valid = (i % 3) != 2;
      in_addr  = OFF + 64'(i) * 64'h8_0000 + 64'h1_0000_0000 * 64'(i % 2);
    end
    @(negedge clk); in_valid = 0;
    repeat (2) @(negedge clk);
    #1; checks++;
    if (out_valid !== 0 || out_hit !== 0 || out_miss !== 0) begin
      errors++; $display("FAIL R9 idle: act %b%b%b exp 000", out_valid, out_hit, out_miss);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule